// File: doc/BRIEF.md
# Serial Flash Erase and Status Command Front-End

This block is the device-side command logic of a serial flash memory. It watches a four-wire serial bus (clock, active-low select, data in, data out), shifts in an 8-bit opcode while select is low, and acts on three commands. The first arms a write-enable latch. The second, which has two opcode values, erases the whole array. The third streams back a status byte. All serial inputs are synchronised into the system clock domain and their edges are detected there. Both serial clock idle levels (low and high) are therefore accepted.

An erase is committed only when select returns high after exactly eight opcode bits. The write-enable latch must be set and every protection bit must be clear. An accepted erase raises a one-cycle `erase_start` pulse, which stands in for the array. It also starts a self-timed busy period of `ERASE_CYCLES` system clocks. The status byte can be read at any time and repeats for as long as the serial clock keeps running. The data-out pin has a separate enable, and the pad is high impedance whenever that enable is low.

Top module: `flash_erase_status_fe`

## Requirements
- R1: After reset, `so_en` is low, no `erase_start` pulse occurs, and the status byte reads 0x00 when `prot_cfg` is zero.
- R2: Opcode 0x06, completed with exactly eight bits, sets the write-enable latch, which is status bit 1.
- R3: Opcode 0x60 or 0xC7 with the latch set, all protection bits zero and not busy produces exactly one single-cycle `erase_start` pulse after select rises. Status bit 0 (busy) then reads 1.
- R4: An erase opcode received while the write-enable latch is clear produces no pulse and leaves the status unchanged.
- R5: An erase opcode received while any protection bit is non-zero produces no pulse and clears the write-enable latch.
- R6: If select rises after any bit count other than eight, the command is discarded and the status is left unchanged.
- R7: The busy bit clears `ERASE_CYCLES` system clocks after acceptance. The write-enable latch clears at the same moment.
- R8: Opcode 0x05 returns the status byte MSB first, one bit per serial clock falling edge. The byte repeats without a gap while clocking continues. Bits 5:2 of the byte follow `prot_cfg`, and bits 7:6 read 0.
- R9: `so_en` stays low during the opcode phase and whenever select is high.
- R10: While busy, write-enable and erase opcodes are ignored, but status reads are still answered.
- R11: Commands behave the same whether the serial clock idles low or idles high.
- R12: No `erase_start` pulse occurs while select is still low, even after all eight bits of an erase opcode have arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in, sampled on the rising serial clock edge |
| prot_cfg | input | 4 | Protection bits, shown as status bits 5:2 |
| so_data | output | 1 | Serial data out value |
| so_en | output | 1 | Data-out drive enable; the pad is high impedance when low |
| erase_start | output | 1 | One-cycle pulse for an accepted whole-array erase |

## Verification
The assertions assume that the serial inputs change slowly compared with the system clock, so that every serial clock edge is seen by the two-stage synchroniser. They also assume that `prot_cfg` is static while a command is in flight. The stimulus holds each serial clock phase for eight system clocks and changes data and select only while the serial clock is low or idle. It changes `prot_cfg` only while select is high. Under these conditions each host edge maps to exactly one detected edge, and the accept decision sees settled protection bits.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
    localparam int OP_BITS = 8;

    typedef logic [OP_BITS-1:0] byte_t;

    typedef enum logic [7:0] {
        OP_WREN    = 8'h06,
        OP_ERASE_A = 8'h60,
        OP_ERASE_B = 8'hC7,
        OP_RDSTAT  = 8'h05
    } opcode_e;

    typedef struct packed {
        logic [1:0] rsvd;
        logic [3:0] prot;
        logic       wel;
        logic       busy;
    } status_t;

    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic cs_rise;
        logic cs_high;
        logic si;
    } spi_evt_t;

    function automatic logic is_erase(byte_t op);
        return (op == OP_ERASE_A) || (op == OP_ERASE_B);
    endfunction
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync
    import sfe_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sck,
    input  logic     cs_n,
    input  logic     si,
    output spi_evt_t evt
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sck_p, cs_p, si_p;
    logic          sck_d, cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p <= '0;
            cs_p  <= '1;
            si_p  <= '0;
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_p <= {sck_p[LAST-1:0], sck};
            cs_p  <= {cs_p[LAST-1:0], cs_n};
            si_p  <= {si_p[LAST-1:0], si};
            sck_d <= sck_p[LAST];
            cs_d  <= cs_p[LAST];
        end
    end

    always_comb begin
        evt.sck_rise = sck_p[LAST] & ~sck_d & ~cs_p[LAST];
        evt.sck_fall = ~sck_p[LAST] & sck_d & ~cs_p[LAST];
        evt.cs_rise  = cs_p[LAST] & ~cs_d;
        evt.cs_high  = cs_p[LAST];
        evt.si       = si_p[LAST];
    end
endmodule

// File: rtl/sfe_opdec.sv
module sfe_opdec
    import sfe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  spi_evt_t evt,
    input  status_t  stat,
    output byte_t    cmd_op,
    output logic     cmd_valid,
    output logic     so_bit,
    output logic     so_oe
);
    localparam int CNT_W   = $clog2(OP_BITS + 2);
    localparam int IDX_W   = $clog2(OP_BITS);
    localparam int CNT_MAX = OP_BITS + 1;

    logic [CNT_W-1:0] bit_cnt;
    byte_t            op_sr;
    byte_t            snap;
    logic [IDX_W-1:0] idx;
    logic             full, rd_phase;

    assign full     = (bit_cnt == CNT_W'(OP_BITS));
    assign rd_phase = (bit_cnt >= CNT_W'(OP_BITS)) && (op_sr == OP_RDSTAT);

    always_ff @(posedge clk) begin
        if (rst || evt.cs_high) begin
            bit_cnt <= '0;
            op_sr   <= '0;
            snap    <= '0;
            idx     <= '0;
            so_oe   <= 1'b0;
        end else begin
            if (evt.sck_rise) begin
                if (bit_cnt < CNT_W'(OP_BITS))
                    op_sr <= {op_sr[OP_BITS-2:0], evt.si};
                if (bit_cnt < CNT_W'(CNT_MAX))
                    bit_cnt <= bit_cnt + 1'b1;
            end
            if (evt.sck_fall && rd_phase) begin
                if (!so_oe || idx == '0) begin
                    so_oe <= 1'b1;
                    snap  <= stat;
                    idx   <= IDX_W'(OP_BITS - 1);
                end else begin
                    idx <= idx - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid <= 1'b0;
            cmd_op    <= '0;
        end else begin
            cmd_valid <= evt.cs_rise && full;
            cmd_op    <= op_sr;
        end
    end

    assign so_bit = snap[idx];
endmodule

// File: rtl/sfe_timer.sv
module sfe_timer #(
    parameter int CYCLES = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (start)
            remain <= CW'(CYCLES);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
    assign done = (remain == CW'(1));
endmodule

// File: rtl/flash_erase_status_fe.sv
module flash_erase_status_fe
    import sfe_pkg::*;
#(
    parameter int ERASE_CYCLES = 50000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       si,
    input  logic [3:0] prot_cfg,
    output logic       so_data,
    output logic       so_en,
    output logic       erase_start
);
    spi_evt_t evt;
    status_t  stat;
    byte_t    cmd_op;
    logic     cmd_valid, busy, done, wel_q, accept, reject;
    logic [3:0] prot_q;

    sfe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .evt(evt)
    );

    sfe_opdec u_dec (
        .clk(clk), .rst(rst), .evt(evt), .stat(stat),
        .cmd_op(cmd_op), .cmd_valid(cmd_valid), .so_bit(so_data), .so_oe(so_en)
    );

    sfe_timer #(.CYCLES(ERASE_CYCLES)) u_tmr (
        .clk(clk), .rst(rst), .start(accept), .busy(busy), .done(done)
    );

    assign accept = cmd_valid && is_erase(cmd_op) && !busy && wel_q && (prot_q == '0);
    assign reject = cmd_valid && is_erase(cmd_op) && !busy && !accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_q      <= '0;
            wel_q       <= 1'b0;
            erase_start <= 1'b0;
        end else begin
            prot_q      <= prot_cfg;
            erase_start <= accept;
            if (done || reject)
                wel_q <= 1'b0;
            else if (cmd_valid && !busy && cmd_op == OP_WREN)
                wel_q <= 1'b1;
        end
    end

    always_comb begin
        stat.rsvd = 2'b00;
        stat.prot = prot_q;
        stat.wel  = wel_q;
        stat.busy = busy;
    end
endmodule

// File: rtl/sfe_chk.sv
module sfe_chk (
    input logic       clk,
    input logic       rst,
    input logic       erase_start,
    input logic       busy,
    input logic       wel,
    input logic [3:0] prot,
    input logic       cs_s,
    input logic       so_oe
);
    p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
        erase_start |=> !erase_start);

    p_busy_with_start_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> erase_start);

    p_start_gated_r4: assert property (@(posedge clk) disable iff (rst)
        erase_start |-> ($past(wel) && !$past(busy)));

    p_start_unprot_r5: assert property (@(posedge clk) disable iff (rst)
        erase_start |-> ($past(prot) == 4'b0000));

    p_wel_clears_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);

    p_so_idle_r9: assert property (@(posedge clk) disable iff (rst)
        cs_s |=> !so_oe);

    p_no_start_cs_low_r12: assert property (@(posedge clk) disable iff (rst)
        erase_start |-> cs_s);
endmodule

bind flash_erase_status_fe sfe_chk u_chk (
    .clk(clk), .rst(rst), .erase_start(erase_start), .busy(busy),
    .wel(wel_q), .prot(prot_q), .cs_s(evt.cs_high), .so_oe(so_en)
);

// File: tb/tb_flash_erase_status_fe.sv
module tb_flash_erase_status_fe;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int ECYC = 2000;
    localparam int H    = 8;

    logic clk = 1'b0, rst = 1'b1, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic [3:0] prot_cfg = 4'h0;
    logic so_data, so_en, erase_start;

    int checks = 0, errors = 0, pulses = 0;
    logic [7:0] exp_q[$];
    logic [7:0] rd_byte;
    event byte_ev;
    bit finished = 1'b0;

    flash_erase_status_fe #(.ERASE_CYCLES(ECYC)) dut (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .prot_cfg(prot_cfg),
        .so_data(so_data), .so_en(so_en), .erase_start(erase_start)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) if (!rst && erase_start) pulses++;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic waith(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops an expected status byte for each byte the design returns.
    initial forever begin
        @(byte_ev);
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected byte", rd_byte, 0);
        else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(rd_byte == e, "R8 status byte", rd_byte, e);
        end
    end

    task automatic spi_cmd(input logic [7:0] op, input int nbits, input bit m3, input int nrd);
        int p0;
        sck = m3;
        waith(H);
        cs_n = 1'b0;
        p0 = pulses;
        waith(H);
        for (int i = 0; i < nbits; i++) begin
            si  = op[7 - (i % 8)];
            sck = 1'b0;
            waith(H);
            if (i == 3) chk(!so_en, "R9 so_en in opcode phase", so_en, 0);
            sck = 1'b1;
            waith(H);
        end
        for (int b = 0; b < nrd; b++) begin
            logic [7:0] got;
            bit en_ok;
            en_ok = 1'b1;
            for (int k = 0; k < 8; k++) begin
                sck = 1'b0;
                waith(H);
                got[7-k] = so_data;
                if (!so_en) en_ok = 1'b0;
                sck = 1'b1;
                waith(H);
            end
            chk(en_ok, "R8 so_en during data", en_ok, 1);
            rd_byte = got;
            -> byte_ev;
        end
        if (!m3) begin
            sck = 1'b0;
            waith(H);
        end
        chk(pulses == p0, "R12 no pulse while select low", pulses - p0, 0);
        cs_n = 1'b1;
        waith(2 * H);
        chk(!so_en, "R9 so_en with select high", so_en, 0);
        sck = m3;
    endtask

    task automatic rd_status(input logic [7:0] e, input int n, input bit m3);
        for (int i = 0; i < n; i++) exp_q.push_back(e);
        spi_cmd(8'h05, 8, m3, n);
    endtask

    initial begin
        int p;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        waith(4);
        // R1 reset state
        chk(!so_en, "R1 so_en after reset", so_en, 0);
        chk(!erase_start && pulses == 0, "R1 no pulse after reset", pulses, 0);
        rd_status(8'h00, 1, 1'b0);                         // R1 R8

        // R4 erase without write enable
        p = pulses;
        spi_cmd(8'h60, 8, 1'b0, 0);
        chk(pulses == p, "R4 erase without latch", pulses - p, 0);
        rd_status(8'h00, 1, 1'b0);

        // R6 wrong bit counts
        spi_cmd(8'h06, 7, 1'b0, 0);
        rd_status(8'h00, 1, 1'b0);                         // R6 seven bits
        spi_cmd(8'h06, 9, 1'b0, 0);
        rd_status(8'h00, 1, 1'b0);                         // R6 nine bits

        // R2 write enable
        spi_cmd(8'h06, 8, 1'b0, 0);
        rd_status(8'h02, 1, 1'b0);

        // R6 truncated erase leaves latch set
        p = pulses;
        spi_cmd(8'hC7, 7, 1'b0, 0);
        chk(pulses == p, "R6 truncated erase", pulses - p, 0);
        rd_status(8'h02, 1, 1'b0);

        // R5 protection blocks erase and clears latch; R8 bits 5:2
        prot_cfg = 4'b0100;
        waith(4);
        rd_status(8'h12, 1, 1'b0);
        p = pulses;
        spi_cmd(8'h60, 8, 1'b0, 0);
        chk(pulses == p, "R5 protected erase", pulses - p, 0);
        rd_status(8'h10, 1, 1'b0);
        prot_cfg = 4'b0000;
        waith(4);

        // R11 idle-high clock; R3 erase 0x60
        spi_cmd(8'h06, 8, 1'b1, 0);
        rd_status(8'h02, 1, 1'b1);
        p = pulses;
        spi_cmd(8'h60, 8, 1'b1, 0);
        chk(pulses == p + 1, "R3 R11 erase 0x60 pulse", pulses - p, 1);
        rd_status(8'h03, 2, 1'b1);                         // R8 repeat, R10 read while busy

        // R10 erase ignored while busy
        p = pulses;
        spi_cmd(8'hC7, 8, 1'b0, 0);
        chk(pulses == p, "R10 erase while busy", pulses - p, 0);
        rd_status(8'h03, 1, 1'b0);

        // R7 busy ends and latch clears
        waith(ECYC + 100);
        rd_status(8'h00, 1, 1'b0);

        // R3 erase 0xC7, R7 still busy midway
        spi_cmd(8'h06, 8, 1'b0, 0);
        p = pulses;
        spi_cmd(8'hC7, 8, 1'b0, 0);
        chk(pulses == p + 1, "R3 erase 0xC7 pulse", pulses - p, 1);
        waith(ECYC / 2);
        rd_status(8'h03, 1, 1'b0);
        waith(ECYC);
        rd_status(8'h00, 3, 1'b0);                         // R7 R8 three repeats
        waith(10);
        chk(exp_q.size() == 0, "R8 all bytes returned", exp_q.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule